// File: doc/BRIEF.md
# DMA Global Control and Status Flags

This block is the control and status register set shared by a four-channel DMA engine. It keeps one operation register with a master enable and two global fault flags: one for an address error raised by the DMA logic and one for a non-maskable interrupt. It also keeps one control register per channel with that channel's enable and its transfer-end flag. Single-cycle event pulses from the rest of the DMA engine set the flags. Software reaches every register through a simple synchronous bus that has byte-lane enables.

Every flag is sticky. Software can clear a flag only by writing 0 to it after a read has returned it as 1, with no other write to that register in between. From the register state the block derives one "may run" qualifier per channel. Any global fault, or the channel's own transfer-end flag, withdraws that qualifier, and the master enable and channel enable must both be set for it to be raised.

Top module: `dma_ctl_flags`

## Requirements
- R1: Reads are combinational while `bus_sel`=1 and `bus_wr`=0. Word offset 0 returns the operation register with bit 2 = address-error flag, bit 1 = NMI flag, bit 0 = master enable. Word offset 1+k returns channel k's register with bit 1 = transfer-end flag and bit 0 = channel enable. All other bits, all unmapped offsets and idle cycles read 0.
- R2: After reset the master enable, all channel enables and all flags are 0, and `ch_run` is 0.
- R3: A write with `bus_be[0]`=1 loads the master enable (offset 0, bit 0) or the channel enable (offset 1+k, bit 0) from the write data on the next clock edge.
- R4: `addr_err_pulse` sets the address-error flag, `nmi_pulse` sets the NMI flag, and `ch_done[k]` sets channel k's transfer-end flag, each visible one cycle later.
- R5: Writing 1 to a flag bit leaves the flag unchanged. Writing 0 to a flag that has not been armed by a read also leaves it unchanged.
- R6: A read that returns a flag as 1 arms that flag. A later write with `bus_be[0]`=1 and 0 in the flag bit clears it. Any write to the same register in between, with any byte enables, disarms it.
- R7: When a set event and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R8: While `standby` is 1, every transfer-end flag is held at 0 and disarmed, and `ch_done` is ignored. The two global flags are not affected.
- R9: `ch_run[k]` is 1 exactly when master enable and channel k's enable are 1 and the address-error flag, the NMI flag and channel k's transfer-end flag are all 0.
- R10: 8-, 16- and 32-bit accesses are accepted. All control bits live in byte lane 0, so a write without `bus_be[0]` changes no bit, although it still disarms that register's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_be | input | DATA_W/8 | Byte-lane enables |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| addr_err_pulse | input | 1 | DMA address error event |
| nmi_pulse | input | 1 | Non-maskable interrupt event |
| standby | input | 1 | Standby level, clears transfer-end flags |
| ch_done | input | NUM_CH | Per-channel transfer-count exhausted pulse |
| ch_run | output | NUM_CH | Per-channel permission to transfer |

## Verification
Two functions can land on the same edge: a flag's set event and the software write that would clear it. A transfer-end flag can also see its completion pulse in the same cycle as `standby`. Directed sequences arm a flag by reading it and then raise the pulse in the very cycle of the clearing write, and they raise `standby` together with a completion pulse. Constrained random traffic mixes reads, writes, pulses and standby freely, so these collisions also occur in unplanned combinations. Every read value and every `ch_run` value is judged against a bench model built from R5–R8, with set winning over clear and standby winning over set.

// File: rtl/dma_ctl_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets, bit positions and the per-register
// access strobe type of the DMA global control block.
package dma_ctl_pkg;
    // Word offsets; channel k sits at CH_BASE + k.
    localparam int unsigned OP_OFS  = 0;
    localparam int unsigned CH_BASE = 1;

    // Operation register bit positions.
    localparam int unsigned OP_ME_BIT  = 0;
    localparam int unsigned OP_NMI_BIT = 1;
    localparam int unsigned OP_AE_BIT  = 2;

    // Channel register bit positions.
    localparam int unsigned CH_EN_BIT = 0;
    localparam int unsigned CH_TE_BIT = 1;

    // Decoded access to one register in the current cycle.
    typedef struct packed {
        logic rd;     // read of this register
        logic wr;     // write of this register (any lanes)
        logic lane0;  // write carries byte lane 0
    } acc_t;
endpackage

// File: rtl/dma_sticky_flag.sv
`timescale 1ns/1ps
// Module: dma_sticky_flag
// One event flag with read-then-write-zero clear. A hidden arm bit is set
// when a read observes the flag at 1; a later write of 0 on lane 0 clears
// the flag only while armed. Any write to the owning register disarms.
// Priority: force clear > set event > software clear.
// Assumes rd_i and wr_i are never both 1.
module dma_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic force_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic lane_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic armed_q;
    logic sw_clr;

    // Purpose: qualify the software clear with the arm bit.
    always_comb sw_clr = wr_i && lane_i && !wbit_i && armed_q;

    // Purpose: flag state with force-clear, set and software-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)           flag_o <= 1'b0;
        else if (force_clr_i) flag_o <= 1'b0;
        else if (set_i)       flag_o <= 1'b1;
        else if (sw_clr)      flag_o <= 1'b0;
    end

    // Purpose: arm on a read returning 1, disarm on any write or force clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed_q <= 1'b0;
        else if (force_clr_i || wr_i)  armed_q <= 1'b0;
        else if (rd_i && flag_o)       armed_q <= 1'b1;
    end
endmodule

// File: rtl/dma_op_reg.sv
`timescale 1ns/1ps
// Module: dma_op_reg
// Shared operation register: master enable plus the address-error and NMI
// sticky flags. Produces its read word; reserved bits are zero.
// Assumes acc_i is already decoded for this register's offset.
module dma_op_reg
    import dma_ctl_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_t             acc_i,
    input  logic [2:0]       wbits_i,
    input  logic             ae_set_i,
    input  logic             nmi_set_i,
    output logic             me_o,
    output logic             ae_o,
    output logic             nmi_o,
    output logic [REG_W-1:0] rword_o
);
    // Purpose: master enable register, loaded by a lane-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       me_o <= 1'b0;
        else if (acc_i.wr && acc_i.lane0) me_o <= wbits_i[OP_ME_BIT];
    end

    dma_sticky_flag u_ae (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ae_set_i),
        .force_clr_i(1'b0),
        .rd_i       (acc_i.rd),
        .wr_i       (acc_i.wr),
        .lane_i     (acc_i.lane0),
        .wbit_i     (wbits_i[OP_AE_BIT]),
        .flag_o     (ae_o)
    );

    dma_sticky_flag u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (nmi_set_i),
        .force_clr_i(1'b0),
        .rd_i       (acc_i.rd),
        .wr_i       (acc_i.wr),
        .lane_i     (acc_i.lane0),
        .wbit_i     (wbits_i[OP_NMI_BIT]),
        .flag_o     (nmi_o)
    );

    // Purpose: assemble the read word with reserved bits at zero.
    always_comb begin
        rword_o             = '0;
        rword_o[OP_ME_BIT]  = me_o;
        rword_o[OP_NMI_BIT] = nmi_o;
        rword_o[OP_AE_BIT]  = ae_o;
    end
endmodule

// File: rtl/dma_chan_reg.sv
`timescale 1ns/1ps
// Module: dma_chan_reg
// One channel's control register: enable bit and sticky transfer-end flag.
// Standby holds the flag clear and disarmed and masks completion pulses.
// Assumes acc_i is already decoded for this channel's offset.
module dma_chan_reg
    import dma_ctl_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_t             acc_i,
    input  logic [1:0]       wbits_i,
    input  logic             done_i,
    input  logic             standby_i,
    output logic             en_o,
    output logic             te_o,
    output logic [REG_W-1:0] rword_o
);
    // Purpose: channel enable register, loaded by a lane-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_o <= 1'b0;
        else if (acc_i.wr && acc_i.lane0) en_o <= wbits_i[CH_EN_BIT];
    end

    dma_sticky_flag u_te (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (done_i),
        .force_clr_i(standby_i),
        .rd_i       (acc_i.rd),
        .wr_i       (acc_i.wr),
        .lane_i     (acc_i.lane0),
        .wbit_i     (wbits_i[CH_TE_BIT]),
        .flag_o     (te_o)
    );

    // Purpose: assemble the read word with reserved bits at zero.
    always_comb begin
        rword_o            = '0;
        rword_o[CH_EN_BIT] = en_o;
        rword_o[CH_TE_BIT] = te_o;
    end
endmodule

// File: rtl/dma_ctl_flags.sv
`timescale 1ns/1ps
// Module: dma_ctl_flags (top)
// Global control/status for a multi-channel DMA engine: address decode,
// operation register, per-channel registers, read mux and the per-channel
// run qualifier. Assumes a single-cycle bus: one access per asserted cycle.
module dma_ctl_flags
    import dma_ctl_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W/8-1:0]   bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  addr_err_pulse,
    input  logic                  nmi_pulse,
    input  logic                  standby,
    input  logic [NUM_CH-1:0]     ch_done,
    output logic [NUM_CH-1:0]     ch_run
);
    localparam int unsigned BE_W  = DATA_W / 8;
    localparam int unsigned PAD_W = DATA_W - REG_W;

    acc_t              op_acc;
    acc_t              ch_acc  [NUM_CH];
    logic [REG_W-1:0]  op_word;
    logic [REG_W-1:0]  ch_word [NUM_CH];
    logic [REG_W-1:0]  rd_word;
    logic              me_q, ae_q, nmi_q;
    logic [NUM_CH-1:0] en_q, te_q;
    logic              unused_bus;

    // Purpose: mark bus bits that hold no control bit as intentionally unused.
    assign unused_bus = ^{bus_wdata[DATA_W-1:3], bus_be[BE_W-1:1]};

    // Purpose: decode the operation register access strobes.
    always_comb begin
        op_acc.rd    = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OP_OFS));
        op_acc.wr    = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OP_OFS));
        op_acc.lane0 = bus_be[0];
    end

    dma_op_reg #(.REG_W(REG_W)) u_op (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (op_acc),
        .wbits_i  (bus_wdata[2:0]),
        .ae_set_i (addr_err_pulse),
        .nmi_set_i(nmi_pulse),
        .me_o     (me_q),
        .ae_o     (ae_q),
        .nmi_o    (nmi_q),
        .rword_o  (op_word)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_OFS = ADDR_W'(CH_BASE + k);

        // Purpose: decode this channel's access strobes.
        always_comb begin
            ch_acc[k].rd    = bus_sel && !bus_wr && (bus_addr == CH_OFS);
            ch_acc[k].wr    = bus_sel &&  bus_wr && (bus_addr == CH_OFS);
            ch_acc[k].lane0 = bus_be[0];
        end

        dma_chan_reg #(.REG_W(REG_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_i    (ch_acc[k]),
            .wbits_i  (bus_wdata[1:0]),
            .done_i   (ch_done[k]),
            .standby_i(standby),
            .en_o     (en_q[k]),
            .te_o     (te_q[k]),
            .rword_o  (ch_word[k])
        );

        // Purpose: channel may run only with both enables and no flag set.
        assign ch_run[k] = me_q && en_q[k] && !ae_q && !nmi_q && !te_q[k];
    end

    // Purpose: select the word of the register being read, zero otherwise.
    always_comb begin
        rd_word = op_acc.rd ? op_word : '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (ch_acc[k].rd) rd_word = ch_word[k];
        end
    end

    // Purpose: zero-extend the register word onto the data bus.
    assign bus_rdata = {{PAD_W{1'b0}}, rd_word};
endmodule

// File: rtl/dma_ctl_flags_chk.sv
`timescale 1ns/1ps
// Module: dma_ctl_flags_chk
// Concurrent checks on the DMA global control block, bound to the top.
module dma_ctl_flags_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              be0,
    input logic              wd_me,
    input logic              wd_ae,
    input logic              addr_err_pulse,
    input logic              nmi_pulse,
    input logic              standby,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_run,
    input logic              me_q,
    input logic              ae_q,
    input logic              nmi_q,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] te_q
);
    logic op_wr;
    assign op_wr = bus_sel && bus_wr && (bus_addr == '0);

    assert_ae_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_pulse |=> ae_q);

    assert_nmi_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> nmi_q);

    assert_ae_w1_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && be0 && wd_ae && ae_q) |=> ae_q);

    assert_ae_clr_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ae_q) |-> $past(op_wr && be0 && !wd_ae));

    assert_me_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_wr && be0) |=> $stable(me_q));

    assert_me_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && be0) |=> (me_q == $past(wd_me)));

    assert_standby_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (te_q == '0));

    assert_fault_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ae_q || nmi_q || !me_q) |-> (ch_run == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        assert_te_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[k] && !standby) |=> te_q[k]);

        assert_run_chan_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (te_q[k] || !en_q[k]) |-> !ch_run[k]);
    end
endmodule

bind dma_ctl_flags dma_ctl_flags_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .be0           (bus_be[0]),
    .wd_me         (bus_wdata[0]),
    .wd_ae         (bus_wdata[2]),
    .addr_err_pulse(addr_err_pulse),
    .nmi_pulse     (nmi_pulse),
    .standby       (standby),
    .ch_done       (ch_done),
    .ch_run        (ch_run),
    .me_q          (me_q),
    .ae_q          (ae_q),
    .nmi_q         (nmi_q),
    .en_q          (en_q),
    .te_q          (te_q)
);

// File: tb/dma_ctl_flags_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against
// a bench-side model of the register behaviour.
module dma_ctl_flags_tb_top;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic addr_err_pulse = 1'b0, nmi_pulse = 1'b0, standby = 1'b0;
    logic [NCH-1:0] ch_done = '0;
    logic [NCH-1:0] ch_run;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    logic m_me = 0, m_ae = 0, m_nmi = 0, m_arm_ae = 0, m_arm_nmi = 0;
    logic [NCH-1:0] m_en = '0, m_te = '0, m_arm_te = '0;

    always #4 clk = ~clk;  // 125 MHz

    dma_ctl_flags dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .addr_err_pulse(addr_err_pulse),
        .nmi_pulse(nmi_pulse), .standby(standby), .ch_done(ch_done),
        .ch_run(ch_run)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return {29'b0, m_ae, m_nmi, m_me};
        if (a >= 4'd1 && a <= 4'(NCH)) return {30'b0, m_te[a-1], m_en[a-1]};
        return 32'b0;
    endfunction

    function automatic logic [NCH-1:0] exp_run();
        logic [NCH-1:0] r;
        for (int k = 0; k < NCH; k++)
            r[k] = m_me && m_en[k] && !m_ae && !m_nmi && !m_te[k];
        return r;
    endfunction

    // One bus cycle: drive at negedge, check outputs, update model at the edge.
    task automatic cyc(input logic sel, input logic wr, input logic [3:0] addr,
                       input logic [3:0] be, input logic [31:0] wd,
                       input logic aep, input logic nmip, input logic stb,
                       input logic [NCH-1:0] dn, input string tag);
        logic n_ae, n_nmi, n_aae, n_anmi;
        logic [NCH-1:0] n_te, n_ate;
        logic opw, opr;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_be = be; bus_wdata = wd;
        addr_err_pulse = aep; nmi_pulse = nmip; standby = stb; ch_done = dn;
        #1;
        chk({tag, " R1 rdata"}, bus_rdata, (sel && !wr) ? exp_read(addr) : 32'b0);
        chk({tag, " R9 ch_run"}, 32'(ch_run), 32'(exp_run()));
        @(posedge clk);
        opw = sel && wr && addr == 0;
        opr = sel && !wr && addr == 0;
        n_ae = aep ? 1'b1 : (opw && be[0] && !wd[2] && m_arm_ae) ? 1'b0 : m_ae;
        n_nmi = nmip ? 1'b1 : (opw && be[0] && !wd[1] && m_arm_nmi) ? 1'b0 : m_nmi;
        n_aae = opw ? 1'b0 : (opr && m_ae) ? 1'b1 : m_arm_ae;
        n_anmi = opw ? 1'b0 : (opr && m_nmi) ? 1'b1 : m_arm_nmi;
        for (int k = 0; k < NCH; k++) begin
            logic cw, cr;
            cw = sel && wr && addr == 4'(k + 1);
            cr = sel && !wr && addr == 4'(k + 1);
            if (cw && be[0]) m_en[k] = wd[0];
            n_te[k] = stb ? 1'b0 : dn[k] ? 1'b1 :
                      (cw && be[0] && !wd[1] && m_arm_te[k]) ? 1'b0 : m_te[k];
            n_ate[k] = (stb || cw) ? 1'b0 : (cr && m_te[k]) ? 1'b1 : m_arm_te[k];
        end
        if (opw && be[0]) m_me = wd[0];
        m_ae = n_ae; m_nmi = n_nmi; m_arm_ae = n_aae; m_arm_nmi = n_anmi;
        m_te = n_te; m_arm_te = n_ate;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1, 0, a, 4'hF, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
        cyc(1, 1, a, be, d, 0, 0, 0, '0, tag);
    endtask

    task automatic idle(input logic aep, input logic nmip, input logic stb,
                        input logic [NCH-1:0] dn, input string tag);
        cyc(0, 0, 0, 0, 0, aep, nmip, stb, dn, tag);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R2: reset state
        for (int a = 0; a <= NCH; a++) rd(4'(a), "R2 reset");
        chk("R2 ch_run after reset", 32'(ch_run), 32'd0);

        // R3: enables
        wr(0, 4'h1, 32'h1, "R3 master");
        for (int k = 0; k < NCH; k++) wr(4'(k + 1), 4'h1, 32'h1, "R3 chan");
        idle(0, 0, 0, '0, "R9 all run");
        chk("R9 all channels running", 32'(ch_run), 32'hF);

        // R10: write without lane 0 changes nothing
        wr(0, 4'h2, 32'h0, "R10 lane1 write");
        rd(0, "R10 master kept");

        // R4 / R5 / R6 on the address-error flag
        idle(1, 0, 0, '0, "R4 ae pulse");
        rd(0, "R4 ae visible");
        wr(0, 4'h1, 32'h5, "R5 write one");
        rd(0, "R5 ae kept");                // arms
        wr(0, 4'h1, 32'h5, "R5 write one after arm");  // disarms
        wr(0, 4'h1, 32'h1, "R6 clear disarmed");
        rd(0, "R6 ae still set");
        wr(0, 4'h1, 32'h1, "R6 clear armed");
        rd(0, "R6 ae cleared");
        chk("R6 ae read back", bus_rdata, 32'h1);

        // R6: intervening write on another lane disarms NMI clear
        idle(0, 1, 0, '0, "R4 nmi pulse");
        rd(0, "R6 arm nmi");
        wr(0, 4'h2, 32'h0, "R6 R10 disarm write");
        wr(0, 4'h1, 32'h1, "R6 clear refused");
        rd(0, "R6 nmi still set");
        wr(0, 4'h1, 32'h1, "R6 clear nmi");
        rd(0, "R6 nmi gone");

        // R7: completion pulse in the same cycle as a valid clear
        idle(0, 0, 0, 4'b0010, "R4 done ch1");
        rd(2, "R7 arm te1");
        cyc(1, 1, 2, 4'h1, 32'h1, 0, 0, 0, 4'b0010, "R7 set vs clear");
        rd(2, "R7 te1 stays");
        chk("R7 te1 read", bus_rdata, 32'h3);
        wr(2, 4'h1, 32'h1, "R7 clear te1");
        rd(2, "R7 te1 cleared");

        // R8: standby beats completion and disarms
        idle(0, 0, 0, 4'b0001, "R4 done ch0");
        rd(1, "R8 arm te0");
        idle(0, 0, 1, 4'b1101, "R8 standby with done");
        rd(1, "R8 te0 cleared");
        idle(0, 0, 0, 4'b0001, "R8 done ch0 again");
        wr(1, 4'h1, 32'h1, "R8 clear after disarm");
        rd(1, "R8 te0 still set");
        idle(1, 1, 1, '0, "R8 globals untouched");
        rd(0, "R8 globals read");
        rd(4'd9, "R1 unmapped");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic s, w;
            s = ($urandom % 4) != 0;
            w = $urandom % 2;
            cyc(s, w, 4'($urandom % 7), 4'($urandom), $urandom,
                ($urandom % 20) == 0, ($urandom % 24) == 0, ($urandom % 40) == 0,
                NCH'(($urandom % 6 == 0) ? $urandom : 0), "R1 R7 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule